// File: doc/BRIEF.md
# Bus State Decoder and Single-Stepper

This block sits beside an 8-bit processor that reports its bus activity on two status pins. One pin says whether the processor has let go of its buses, and the other qualifies that report. The block turns the pair into four one-hot state flags. It also raises a flag for each bus cycle that carries no real transfer. Such a cycle can only be recognised by its pattern: an all-ones address, a read, and a low qualifier pin.

The block also drives the processor's active-low halt request. In run mode the request is never asserted. In step mode the processor is kept halted. A step pulse releases it long enough for exactly one instruction. The release ends once the bus-available pin has been seen low for a set number of consecutive bus cycles. Halt is then reasserted, and the processor stops again when that instruction finishes.

The stepper is a four-state machine:
- RUN: halt released, entered whenever run mode is selected.
- HELD: halt asserted and the processor idle, waiting for a step.
- RELEASE: halt released, counting low cycles on the bus-available pin. HELD moves here on a step pulse.
- EXEC: halt asserted again while the instruction finishes. RELEASE moves here after enough consecutive low cycles, and EXEC returns to HELD when the bus-available pin goes high.

Top module: `bus_step_ctrl`

## Requirements
- R1: One cycle after the pins are sampled, the flags give the decode with bus_avail as the high bit and bus_stat as the low bit: 00 sets st_running, 01 sets st_irq_ack, 10 sets st_sync_ack and 11 sets st_halted.
- R2: Exactly one of the four state flags is high at all times after reset; synchronous reset selects st_running.
- R3: idle_cycle is high one cycle after a sampled cycle with every address bit 1, rd_nwr = 1 and bus_stat = 0, and low after any other pattern.
- R4: While step_mode is 0, cpu_halt_n stays 1 regardless of bus_avail and step_req.
- R5: With rst_n low, cpu_halt_n is 0 if step_mode is 1 and 1 if step_mode is 0, from the first clock edge in reset.
- R6: In HELD, a step_req sampled high makes cpu_halt_n 1 from the next cycle. It stays 1 until bus_avail has been sampled low on STEP_LOW_CYC consecutive edges; a high sample restarts the count.
- R7: On the edge that completes the low count, cpu_halt_n returns to 0 and stays 0 until bus_avail is sampled high (EXEC then HELD).
- R8: step_req is ignored in RELEASE and EXEC; a further step is only taken from HELD.
- R9: Changing step_mode from 1 to 0 releases halt at the next edge from any state. Changing it from 0 to 1 enters HELD and asserts halt at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_avail | input | 1 | Processor bus-available status pin |
| bus_stat | input | 1 | Processor bus-status qualifier pin |
| bus_addr | input | ADDR_W | Processor address bus |
| rd_nwr | input | 1 | Read (1) / write (0) line |
| step_mode | input | 1 | 1 = single-step, 0 = run |
| step_req | input | 1 | Debounced step request pulse |
| cpu_halt_n | output | 1 | Active-low halt request to the processor |
| st_running | output | 1 | Normal running flag |
| st_irq_ack | output | 1 | Interrupt acknowledge flag |
| st_sync_ack | output | 1 | Sync acknowledge flag |
| st_halted | output | 1 | Halt or bus grant flag |
| idle_cycle | output | 1 | Cycle with no real bus transfer |

## Verification
The decoder is driven through all four pin codes, so each flag is tied to a single code. The idle detector gets the full idle pattern and then three near misses, each breaking one term: a write, an address one below all ones, and the qualifier high. The stepper gets a low-high-low-low sequence on bus_avail while released. This shows the low count restarts rather than accumulates. Step pulses are also sent during EXEC, and run and step mode are switched while stepping; these show that release is tied to the handshake and not to the pulse or to time.

// File: rtl/bus_step_pkg.sv
package bus_step_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HELD    = 2'd1,
        ST_RELEASE = 2'd2,
        ST_EXEC    = 2'd3
    } step_st_e;

    typedef struct packed {
        logic running;
        logic irq_ack;
        logic sync_ack;
        logic halted;
    } cpu_flags_t;

    localparam cpu_flags_t FLAGS_RESET = '{running: 1'b1, irq_ack: 1'b0,
                                           sync_ack: 1'b0, halted: 1'b0};

endpackage

// File: rtl/bus_stat_decode.sv
module bus_stat_decode
    import bus_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_avail,
    input  logic       bus_stat,
    output cpu_flags_t flags
);

    logic [1:0] code;
    cpu_flags_t flags_nxt;

    assign code = {bus_avail, bus_stat};

    always_comb begin
        flags_nxt = '0;
        unique case (code)
            2'b00: flags_nxt.running  = 1'b1;
            2'b01: flags_nxt.irq_ack  = 1'b1;
            2'b10: flags_nxt.sync_ack = 1'b1;
            2'b11: flags_nxt.halted   = 1'b1;
            default: flags_nxt = FLAGS_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= FLAGS_RESET;
        else        flags <= flags_nxt;
    end

endmodule

// File: rtl/bus_idle_detect.sv
module bus_idle_detect #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_nwr,
    input  logic              bus_stat,
    output logic              idle_cycle
);

    localparam logic [ADDR_W-1:0] IDLE_ADDR = {ADDR_W{1'b1}};

    logic pattern_hit;

    assign pattern_hit = (bus_addr == IDLE_ADDR) && rd_nwr && !bus_stat;

    always_ff @(posedge clk) begin
        if (!rst_n) idle_cycle <= 1'b0;
        else        idle_cycle <= pattern_hit;
    end

endmodule

// File: rtl/step_fsm.sv
module step_fsm
    import bus_step_pkg::*;
#(
    parameter int STEP_LOW_CYC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bus_avail,
    input  logic     step_mode,
    input  logic     step_req,
    output logic     cpu_halt_n,
    output step_st_e state_o
);

    localparam int CNT_W = (STEP_LOW_CYC < 2) ? 1 : $clog2(STEP_LOW_CYC + 1);
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(STEP_LOW_CYC - 1);

    step_st_e   state, state_nxt;
    logic [CNT_W-1:0] low_cnt, low_cnt_nxt;
    logic       low_done;

    assign low_done = !bus_avail && (low_cnt == LOW_LAST);

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (step_mode) state_nxt = ST_HELD;
            end
            ST_HELD: begin
                if (!step_mode)    state_nxt = ST_RUN;
                else if (step_req) state_nxt = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!step_mode)    state_nxt = ST_RUN;
                else if (low_done) state_nxt = ST_EXEC;
            end
            ST_EXEC: begin
                if (!step_mode)    state_nxt = ST_RUN;
                else if (bus_avail) state_nxt = ST_HELD;
            end
            default: state_nxt = ST_HELD;
        endcase
    end

    // consecutive low-cycle counter, live only while released
    always_comb begin
        low_cnt_nxt = '0;
        if (state == ST_RELEASE && step_mode && !bus_avail && !low_done)
            low_cnt_nxt = low_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= step_mode ? ST_HELD : ST_RUN;
            low_cnt <= '0;
        end else begin
            state   <= state_nxt;
            low_cnt <= low_cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        cpu_halt_n = 1'b0;
        unique case (state)
            ST_RUN:     cpu_halt_n = 1'b1;
            ST_HELD:    cpu_halt_n = 1'b0;
            ST_RELEASE: cpu_halt_n = 1'b1;
            ST_EXEC:    cpu_halt_n = 1'b0;
            default:    cpu_halt_n = 1'b0;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/bus_step_ctrl.sv
module bus_step_ctrl
    import bus_step_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int STEP_LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_avail,
    input  logic              bus_stat,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_nwr,
    input  logic              step_mode,
    input  logic              step_req,
    output logic              cpu_halt_n,
    output logic              st_running,
    output logic              st_irq_ack,
    output logic              st_sync_ack,
    output logic              st_halted,
    output logic              idle_cycle
);

    cpu_flags_t flags;
    step_st_e   fsm_state;

    bus_stat_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_avail (bus_avail),
        .bus_stat  (bus_stat),
        .flags     (flags)
    );

    bus_idle_detect #(.ADDR_W(ADDR_W)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .rd_nwr     (rd_nwr),
        .bus_stat   (bus_stat),
        .idle_cycle (idle_cycle)
    );

    step_fsm #(.STEP_LOW_CYC(STEP_LOW_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_avail  (bus_avail),
        .step_mode  (step_mode),
        .step_req   (step_req),
        .cpu_halt_n (cpu_halt_n),
        .state_o    (fsm_state)
    );

    assign st_running  = flags.running;
    assign st_irq_ack  = flags.irq_ack;
    assign st_sync_ack = flags.sync_ack;
    assign st_halted   = flags.halted;

endmodule

// File: rtl/bus_step_chk.sv
module bus_step_chk
    import bus_step_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_avail,
    input logic              bus_stat,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_nwr,
    input logic              step_mode,
    input logic              step_req,
    input logic              cpu_halt_n,
    input logic              st_running,
    input logic              st_irq_ack,
    input logic              st_sync_ack,
    input logic              st_halted,
    input logic              idle_cycle,
    input step_st_e          fsm_state
);

    AST_FLAG_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({st_running, st_irq_ack, st_sync_ack, st_halted} ==
                         {$past(!bus_avail && !bus_stat), $past(!bus_avail && bus_stat),
                          $past(bus_avail && !bus_stat), $past(bus_avail && bus_stat)})); // R1

    AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones({st_running, st_irq_ack, st_sync_ack, st_halted}) == 1)); // R2

    AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (idle_cycle == $past((&bus_addr) && rd_nwr && !bus_stat))); // R3

    AST_RUN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !step_mode && !$past(step_mode)) |-> cpu_halt_n); // R4

    AST_STEP_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HELD && step_mode && step_req) |=> cpu_halt_n); // R6

    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_EXEC && step_mode) |=> !cpu_halt_n); // R8

endmodule

bind bus_step_ctrl bus_step_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_avail   (bus_avail),
    .bus_stat    (bus_stat),
    .bus_addr    (bus_addr),
    .rd_nwr      (rd_nwr),
    .step_mode   (step_mode),
    .step_req    (step_req),
    .cpu_halt_n  (cpu_halt_n),
    .st_running  (st_running),
    .st_irq_ack  (st_irq_ack),
    .st_sync_ack (st_sync_ack),
    .st_halted   (st_halted),
    .idle_cycle  (idle_cycle),
    .fsm_state   (fsm_state)
);

// File: tb/bus_step_ctrl_test.sv
module bus_step_ctrl_test;

    localparam int AW  = 16;
    localparam int LOW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_avail = 1'b1;
    logic          bus_stat = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          rd_nwr = 1'b1;
    logic          step_mode = 1'b1;
    logic          step_req = 1'b0;
    logic          cpu_halt_n, st_running, st_irq_ack, st_sync_ack, st_halted, idle_cycle;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bus_step_ctrl #(.ADDR_W(AW), .STEP_LOW_CYC(LOW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_avail(bus_avail), .bus_stat(bus_stat),
        .bus_addr(bus_addr), .rd_nwr(rd_nwr), .step_mode(step_mode), .step_req(step_req),
        .cpu_halt_n(cpu_halt_n), .st_running(st_running), .st_irq_ack(st_irq_ack),
        .st_sync_ack(st_sync_ack), .st_halted(st_halted), .idle_cycle(idle_cycle)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step_mode = 1'b1; tick(); tick();
        chk("R5 halt in reset, step mode", {3'b0, cpu_halt_n}, 4'b0000);
        chk("R2 reset flags", {st_running, st_irq_ack, st_sync_ack, st_halted}, 4'b1000);
        step_mode = 1'b0; tick();
        chk("R5 halt in reset, run mode", {3'b0, cpu_halt_n}, 4'b0001);
        step_mode = 1'b1; tick();
        rst_n = 1'b1; tick();
        chk("R5 held after reset", {3'b0, cpu_halt_n}, 4'b0000);
    endtask

    task automatic t_decode();
        for (int c = 0; c < 4; c++) begin
            {bus_avail, bus_stat} = 2'(c);
            tick();
            chk("R1 R2 flag decode", {st_running, st_irq_ack, st_sync_ack, st_halted},
                4'b1000 >> c);
        end
        bus_avail = 1'b1; bus_stat = 1'b1; tick();
    endtask

    task automatic t_idle();
        bus_addr = '1; rd_nwr = 1'b1; bus_stat = 1'b0; tick();
        chk("R3 idle pattern", {3'b0, idle_cycle}, 4'b0001);
        rd_nwr = 1'b0; tick();
        chk("R3 write not idle", {3'b0, idle_cycle}, 4'b0000);
        rd_nwr = 1'b1; bus_addr = {{(AW-1){1'b1}}, 1'b0}; tick();
        chk("R3 address miss", {3'b0, idle_cycle}, 4'b0000);
        bus_addr = '1; bus_stat = 1'b1; tick();
        chk("R3 qualifier high", {3'b0, idle_cycle}, 4'b0000);
        bus_addr = '0; tick();
    endtask

    task automatic t_step();
        bus_avail = 1'b1;
        step_req = 1'b1; tick(); step_req = 1'b0;
        chk("R6 released by step", {3'b0, cpu_halt_n}, 4'b0001);
        tick();
        chk("R6 still released", {3'b0, cpu_halt_n}, 4'b0001);
        bus_avail = 1'b0; tick();
        chk("R6 one low not enough", {3'b0, cpu_halt_n}, 4'b0001);
        bus_avail = 1'b1; tick();
        chk("R6 high restarts count", {3'b0, cpu_halt_n}, 4'b0001);
        bus_avail = 1'b0;
        for (int i = 1; i < LOW; i++) begin
            tick();
            chk("R6 counting lows", {3'b0, cpu_halt_n}, 4'b0001);
        end
        tick();
        chk("R7 halt reasserted", {3'b0, cpu_halt_n}, 4'b0000);
        step_req = 1'b1; tick(); step_req = 1'b0;
        chk("R8 step ignored in EXEC", {3'b0, cpu_halt_n}, 4'b0000);
        tick();
        chk("R7 stays halted", {3'b0, cpu_halt_n}, 4'b0000);
        bus_avail = 1'b1; tick();
        chk("R7 held after bus returns", {3'b0, cpu_halt_n}, 4'b0000);
        step_req = 1'b1; tick(); step_req = 1'b0;
        chk("R6 second step taken", {3'b0, cpu_halt_n}, 4'b0001);
        step_req = 1'b1; tick(); step_req = 1'b0;
        chk("R8 step ignored in RELEASE", {3'b0, cpu_halt_n}, 4'b0001);
    endtask

    task automatic t_mode();
        step_mode = 1'b0; tick();
        chk("R9 step to run", {3'b0, cpu_halt_n}, 4'b0001);
        step_mode = 1'b1; tick();
        chk("R9 run to step", {3'b0, cpu_halt_n}, 4'b0000);
    endtask

    task automatic t_run();
        step_mode = 1'b0;
        for (int i = 0; i < 6; i++) begin
            bus_avail = i[0]; step_req = i[1];
            tick();
            chk("R4 run mode free", {3'b0, cpu_halt_n}, 4'b0001);
        end
        step_req = 1'b0; bus_avail = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        summary();
    end

    initial begin
        t_reset();
        t_decode();
        t_idle();
        t_step();
        t_mode();
        t_run();
        summary();
    end

endmodule